// File: doc/BRIEF.md
# Integer Register File with Hardwired Zero Entry

This block holds the general-purpose integer registers of a small load/store processor: 32 entries of 64 bits each. Two read ports, each with its own address, return register values combinationally. A write port stores one value on each rising clock edge when its enable is high. The program counter is kept elsewhere in the core and has no entry here.

Entry 0 is a constant zero. It reads as zero on both ports, and a write aimed at it is discarded. The write address goes through a decoder that raises at most one per-entry enable. All enables stay low while the global write enable is low. Each read port chooses its entry through its own multiplexer. A synchronous reset clears every entry.

Top module: `zreg_file`

## Requirements
- R1: The file has 32 entries selected by 5-bit addresses 0 to 31. Entry 31, the highest address, is fully writable and readable.
- R2: Reading address 0 on either port returns all zeros at all times.
- R3: A write with `wr_en`=1 and `wr_addr`=0 changes no entry. Address 0 still reads zero, and every other entry keeps its value.
- R4: A write with `wr_en`=1 to an address k from 1 to 31 stores `wr_data` into entry k on the rising clock edge. It is readable in the cycle after that edge.
- R5: While `wr_en`=0, no entry changes, whatever `wr_addr` and `wr_data` hold.
- R6: At most one entry is updated per clock edge: only the addressed entry, and no other.
- R7: A clock edge with `rst`=1 clears all entries to zero, even if a write is requested in the same cycle.
- R8: Reads are combinational. A read of the entry being written in the same cycle returns the value from before the edge.
- R9: The two read ports are independent. They may use different addresses or the same address, and each returns its own selected entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on the rising edge |
| rst | input | 1 | Synchronous reset, active high; clears all entries |
| rd_addr_a | input | 5 | Address for read port A |
| rd_data_a | output | 64 | Combinational value of the entry at `rd_addr_a` |
| rd_addr_b | input | 5 | Address for read port B |
| rd_data_b | output | 64 | Combinational value of the entry at `rd_addr_b` |
| wr_en | input | 1 | Global write enable |
| wr_addr | input | 5 | Entry to write |
| wr_data | input | 64 | Value to write |

## Verification
The bench builds the block with its default parameters: 32 entries of 64 bits. This makes address 31 and the full 5-bit address field reachable, along with data patterns whose upper 32 bits differ from the lower half. Random traffic mixes enabled and disabled writes across all addresses, including address 0. Directed cases then do the following:
- Sweep every entry through both ports after a reset.
- Sweep every entry through both ports after writes that should have no effect.
- Read an entry in the same cycle it is written.
- Request a write at the same time as a reset.

// File: rtl/zrf_pkg.sv
package zrf_pkg;
    localparam int unsigned ZRF_ENTRIES = 32;
    localparam int unsigned ZRF_WIDTH   = 64;
    localparam int unsigned ZRF_RD_PORTS = 2;
endpackage

// File: rtl/zrf_wr_decode.sv
module zrf_wr_decode #(
    parameter int unsigned NUM_ENTRIES = zrf_pkg::ZRF_ENTRIES,
    localparam int unsigned ADDR_W = $clog2(NUM_ENTRIES)
) (
    input  logic                   wr_en_i,
    input  logic [ADDR_W-1:0]      wr_addr_i,
    output logic [NUM_ENTRIES-1:0] sel_o
);
    // Entry 0 never receives an enable; the others are gated by wr_en_i.
    assign sel_o[0] = 1'b0;
    for (genvar i = 1; i < NUM_ENTRIES; i++) begin : g_sel
        assign sel_o[i] = wr_en_i && (wr_addr_i == ADDR_W'(i));
    end
endmodule

// File: rtl/zrf_rd_mux.sv
module zrf_rd_mux #(
    parameter int unsigned NUM_ENTRIES = zrf_pkg::ZRF_ENTRIES,
    parameter int unsigned DATA_W      = zrf_pkg::ZRF_WIDTH,
    localparam int unsigned ADDR_W = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0][DATA_W-1:0] ent_i,
    input  logic [ADDR_W-1:0]                  addr_i,
    output logic [DATA_W-1:0]                  data_o
);
    always_comb begin
        data_o = '0;
        if (addr_i != '0 && 32'(addr_i) < NUM_ENTRIES) begin
            data_o = ent_i[addr_i];
        end
    end
endmodule

// File: rtl/zreg_file.sv
module zreg_file #(
    parameter int unsigned NUM_ENTRIES = zrf_pkg::ZRF_ENTRIES,
    parameter int unsigned DATA_W      = zrf_pkg::ZRF_WIDTH,
    localparam int unsigned ADDR_W = $clog2(NUM_ENTRIES),
    localparam int unsigned NUM_RD = zrf_pkg::ZRF_RD_PORTS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    typedef struct packed {
        logic [NUM_ENTRIES-1:0][DATA_W-1:0] ent;
    } state_t;

    state_t st_d, st_q;
    logic [NUM_ENTRIES-1:0] wr_sel;
    logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr;
    logic [NUM_RD-1:0][DATA_W-1:0] rd_data;

    zrf_wr_decode #(.NUM_ENTRIES(NUM_ENTRIES)) u_dec (
        .wr_en_i  (wr_en),
        .wr_addr_i(wr_addr),
        .sel_o    (wr_sel)
    );

    always_comb begin
        st_d = st_q;
        for (int i = 1; i < NUM_ENTRIES; i++) begin
            if (wr_sel[i]) st_d.ent[i] = wr_data;
        end
        st_d.ent[0] = '0;
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_addr[0] = rd_addr_a;
    assign rd_addr[1] = rd_addr_b;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        zrf_rd_mux #(.NUM_ENTRIES(NUM_ENTRIES), .DATA_W(DATA_W)) u_mux (
            .ent_i (st_q.ent),
            .addr_i(rd_addr[p]),
            .data_o(rd_data[p])
        );
    end

    assign rd_data_a = rd_data[0];
    assign rd_data_b = rd_data[1];

    AST_SINGLE_ENABLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_sel)) else $error("enable not one-hot"); // R6
    AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_a == '0) |-> (rd_data_a == '0)) else $error("port A zero"); // R2
    AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_b == '0) |-> (rd_data_b == '0)) else $error("port B zero"); // R2
    AST_ZERO_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == '0) |=> $stable(st_q)) else $error("zero write"); // R3
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != '0) |=> (st_q.ent[$past(wr_addr)] == $past(wr_data)))
        else $error("write lost"); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(st_q)) else $error("idle change"); // R5
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (st_q == '0)) else $error("reset"); // R7
endmodule

// File: tb/zreg_file_tb.sv
module zreg_file_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  rd_addr_a, rd_addr_b, wr_addr;
    logic [63:0] rd_data_a, rd_data_b, wr_data;
    logic        wr_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [63:0] mdl [32];

    always #5 clk = ~clk;

    zreg_file dut_i (
        .clk(clk), .rst(rst),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    function automatic logic [63:0] exp_rd(logic [4:0] a);
        return (a == 5'd0) ? 64'd0 : mdl[a];
    endfunction

    task automatic chk(logic [63:0] act, logic [63:0] exp, string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // One cycle: drive inputs, check reads before the edge, update the model at the edge.
    task automatic step(bit we, logic [4:0] wa, logic [63:0] wd,
                        logic [4:0] ra, logic [4:0] rb, bit rs, string tag);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_addr_a = ra; rd_addr_b = rb; rst = rs;
        #1;
        chk(rd_data_a, exp_rd(ra), tag);
        chk(rd_data_b, exp_rd(rb), tag);
        @(posedge clk);
        if (rs) begin
            for (int i = 0; i < 32; i++) mdl[i] = 64'd0;
        end else if (we && wa != 5'd0) begin
            mdl[wa] = wd;
        end
    endtask

    // Read every entry through both ports with writes disabled.
    task automatic sweep(string tag);
        @(negedge clk);
        wr_en = 1'b0; rst = 1'b0;
        for (int a = 0; a < 32; a++) begin
            rd_addr_a = 5'(a);
            rd_addr_b = 5'(31 - a);
            #1;
            chk(rd_data_a, exp_rd(5'(a)), tag);
            chk(rd_data_b, exp_rd(5'(31 - a)), tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd2025));
        for (int i = 0; i < 32; i++) mdl[i] = 64'd0;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr_a = '0; rd_addr_b = '0;
        repeat (2) @(posedge clk);
        sweep("R7 reset state");

        // R1: fill every entry including the boundary address 31
        for (int a = 1; a < 32; a++)
            step(1'b1, 5'(a), {32'hA5A50000 | 32'(a), 32'(a) * 32'h01010101},
                 5'(a - 1), 5'd31, 1'b0, "R1 fill");
        sweep("R1 full sweep");

        // R3: writes to entry 0 are dropped
        step(1'b1, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 5'd0, 5'd1, 1'b0, "R3 zero write");
        step(1'b1, 5'd0, 64'h1234_5678_9ABC_DEF0, 5'd0, 5'd0, 1'b0, "R3 zero write");
        sweep("R3 after zero writes");

        // R5: disabled writes leave all entries alone
        for (int a = 0; a < 32; a++)
            step(1'b0, 5'(a), ~64'(a), 5'(a), 5'(a), 1'b0, "R5 disabled write");
        sweep("R5 after disabled writes");

        // R8: same-cycle read returns the old value, new value one cycle later
        step(1'b1, 5'd7, 64'hDEAD_BEEF_CAFE_F00D, 5'd7, 5'd7, 1'b0, "R8 old value");
        step(1'b0, 5'd0, 64'd0, 5'd7, 5'd6, 1'b0, "R4 R9 new value");
        chk(rd_data_a, 64'hDEAD_BEEF_CAFE_F00D, "R4 readback");

        // R2: zero on both ports while other entries are nonzero
        step(1'b0, 5'd3, 64'd5, 5'd0, 5'd0, 1'b0, "R2 both ports zero");

        // R7: reset wins over a simultaneous write
        step(1'b1, 5'd9, 64'h0BAD_0BAD_0BAD_0BAD, 5'd9, 5'd31, 1'b1, "R7 reset with write");
        sweep("R7 after reset with write");

        // Random traffic, R4 R6 R9 and the rest checked against the model
        for (int n = 0; n < 3000; n++) begin
            step(($urandom % 4) != 0, 5'($urandom), {$urandom, $urandom},
                 5'($urandom), 5'($urandom), ($urandom % 500) == 0, "R4/R6/R9 random");
        end
        sweep("R6 final sweep");
        summary();
    end
endmodule